// File: doc/BRIEF.md
# Instruction Scratchpad Row Loader

This block fills a 128-bit-wide instruction scratchpad from software-visible staging. Two 32-bit staging registers, called upper and lower, are written through plain register write strobes. A store command then carries a byte index and moves the staged pair into one 64-bit half of a scratchpad row. The scratchpad itself sits outside the block. It is driven through a valid/ready write port that has one enable bit per half-row. Filling a whole row takes two stores, one for each half.

The `big_endian` strap decides which staging register holds the instruction that comes first in program order. The block always places that first instruction in the lower-addressed lane of the selected half. Software therefore fills the staging registers in the order that suits the configured endianness, and the scratchpad contents come out the same either way.

Store commands use a valid/ready handshake. Behind the command port there is a single registered write slot. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. At that edge the block computes the row write and loads it into the slot, so the scratchpad write goes out on a following edge. While the slot holds a write that the scratchpad has not taken (`mem_wvalid` high with `mem_wready` low), `cmd_ready` stays low and the pending write stays frozen. When the slot drains at an edge, a new command can be accepted at that same edge, so stores run at one per cycle without a bubble.

Top module: `iscr_loader`

## Requirements
- R1: After reset both staging registers read as zero, `mem_wvalid` is low and `cmd_ready` is high. A store issued with no staging write therefore writes zero data.
- R2: `upper_we` loads `upper_data` and `lower_we` loads `lower_data` at a clock edge. The two strobes act independently and may be asserted together.
- R3: A command is accepted at an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the write slot is empty or is draining (`mem_wready` high) at that edge.
- R4: After a command is accepted, `mem_wvalid` is high and `mem_row` equals `cmd_index[ROW_AW+3:4]`. `mem_wmask` is one-hot, and its bit `cmd_index[3]` is the set bit (bit 0 selects row bits 63:0, bit 1 selects row bits 127:64).
- R5: Half h occupies row bits [64h+63:64h]. When `big_endian` is 1, the upper staging word goes to bits [64h+31:64h] and the lower word to bits [64h+63:64h+32]. When `big_endian` is 0, the two words swap places.
- R6: The data bits of the half that is not selected are zero, and its mask bit is clear. A store therefore never changes the other half, and rows that are never addressed keep their contents.
- R7: `cmd_index[2:0]` has no effect on the write.
- R8: While `mem_wvalid` is high and `mem_wready` is low, the write port holds its row, mask and data and no new command is accepted.
- R9: The staging registers keep their values after a store, so repeated stores to the same index write identical data.
- R10: A store captures the staging values held before its accept edge. A staging write at the accept edge, or while the write is pending, does not alter that store's data.
- R11: If no new command is accepted at the edge where a write drains, `mem_wvalid` falls. Back-to-back commands are accepted on consecutive cycles while `mem_wready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upper_we | input | 1 | Load strobe for the upper staging word |
| upper_data | input | 32 | Upper staging word value |
| lower_we | input | 1 | Load strobe for the lower staging word |
| lower_data | input | 32 | Lower staging word value |
| big_endian | input | 1 | Endianness strap, 1 = big-endian |
| cmd_valid | input | 1 | Store command offered |
| cmd_ready | output | 1 | Store command can be taken |
| cmd_index | input | ROW_AW+4 | Byte index of the store |
| mem_wvalid | output | 1 | Scratchpad write pending |
| mem_wready | input | 1 | Scratchpad takes the write |
| mem_row | output | ROW_AW | Row address of the write |
| mem_wmask | output | 2 | Per-half write enable |
| mem_wdata | output | 128 | Row write data |

## Verification
The assertions assume that reset is applied before the first clock edge and that every input is at a known value after reset. Under those conditions the hold property, the one-hot mask property and the zeroed-half property follow from the design alone, whatever pattern `mem_wready` takes. The stimulus changes inputs only on falling edges and stops at the falling edge, so no input moves near the sampling edge. It changes `big_endian` only while no command is being offered. To exercise R8, it holds `mem_wready` low for several cycles while a second command is waiting.

// File: rtl/iscr_pkg.sv
package iscr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALVES  = 2;
  localparam int unsigned HALF_W  = 2 * WORD_W;
  localparam int unsigned ROW_W   = HALVES * HALF_W;
  localparam int unsigned LOW_IGN = 3;  // byte/word offset bits with no effect
  localparam int unsigned HALF_BIT = 3; // index bit picking the half

  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } order_e;

  // Returns the 64-bit half image: first-in-program-order word in low lane.
  function automatic logic [HALF_W-1:0] order_pair(
    input logic [WORD_W-1:0] upper_w,
    input logic [WORD_W-1:0] lower_w,
    input order_e            ord
  );
    logic [WORD_W-1:0] first_w;
    logic [WORD_W-1:0] second_w;
    first_w  = (ord == ORDER_BIG) ? upper_w : lower_w;
    second_w = (ord == ORDER_BIG) ? lower_w : upper_w;
    return {second_w, first_w};
  endfunction
endpackage

// File: rtl/iscr_staging.sv
module iscr_staging
  import iscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upper_we,
  input  logic [WORD_W-1:0] upper_d,
  input  logic              lower_we,
  input  logic [WORD_W-1:0] lower_d,
  output logic [WORD_W-1:0] upper_q,
  output logic [WORD_W-1:0] lower_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      lower_q <= '0;
    end else begin
      if (upper_we) upper_q <= upper_d;
      if (lower_we) lower_q <= lower_d;
    end
  end

  // R9: staging survives anything but its own strobe
  a_r9_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_we |=> $stable(upper_q));
  a_r9_lower_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lower_we |=> $stable(lower_q));
  // R2: strobe loads the value
  a_r2_upper_load: assert property (@(posedge clk) disable iff (!rst_n)
    upper_we |=> upper_q == $past(upper_d));
endmodule

// File: rtl/iscr_lane_pack.sv
module iscr_lane_pack
  import iscr_pkg::*;
#(
  parameter int unsigned ROW_AW = 3,
  localparam int unsigned IDX_W = ROW_AW + 4
) (
  input  logic              [WORD_W-1:0] upper_w,
  input  logic              [WORD_W-1:0] lower_w,
  input  logic                           big_endian,
  input  logic              [IDX_W-1:0]  index,
  output logic              [ROW_AW-1:0] row,
  output logic              [HALVES-1:0] mask,
  output logic              [ROW_W-1:0]  data
);
  logic              half_sel;
  logic [HALF_W-1:0] pair;
  logic              unused_low;

  assign unused_low = ^index[LOW_IGN-1:0];
  assign half_sel   = index[HALF_BIT];
  assign row        = index[IDX_W-1:HALF_BIT+1];
  assign pair       = order_pair(upper_w, lower_w, order_e'(big_endian));

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign mask[h]                  = (half_sel == 1'(h));
    assign data[h*HALF_W +: HALF_W] = mask[h] ? pair : '0;
  end

  // R4: exactly one half enabled per store image
  always_comb begin
    a_r4_mask_onehot: assert ($countones(mask) == 1 || $isunknown(index));
  end
endmodule

// File: rtl/iscr_wr_stage.sv
module iscr_wr_stage
  import iscr_pkg::*;
#(
  parameter int unsigned ROW_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ROW_AW-1:0] in_row,
  input  logic [HALVES-1:0] in_mask,
  input  logic [ROW_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROW_AW-1:0] out_row,
  output logic [HALVES-1:0] out_mask,
  output logic [ROW_W-1:0]  out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_mask  <= '0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_row   <= in_row;
        out_mask  <= in_mask;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8: a stalled write is frozen
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row)
                                && $stable(out_mask) && $stable(out_data));
  // R11: accept always yields a pending write next cycle
  a_r11_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R11: drain with no new command empties the slot
  a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
  // R6: the unselected half carries no data
  a_r6_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask[0] ? out_data[ROW_W-1:HALF_W] == '0
                               : out_data[HALF_W-1:0] == '0));
endmodule

// File: rtl/iscr_loader.sv
module iscr_loader
  import iscr_pkg::*;
#(
  parameter int unsigned ROW_AW = 3,
  localparam int unsigned IDX_W = ROW_AW + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upper_we,
  input  logic [31:0]       upper_data,
  input  logic              lower_we,
  input  logic [31:0]       lower_data,
  input  logic              big_endian,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_index,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ROW_AW-1:0] mem_row,
  output logic [1:0]        mem_wmask,
  output logic [127:0]      mem_wdata
);
  logic [WORD_W-1:0] upper_q, lower_q;
  logic [ROW_AW-1:0] img_row;
  logic [HALVES-1:0] img_mask;
  logic [ROW_W-1:0]  img_data;

  iscr_staging u_stage (
    .clk(clk), .rst_n(rst_n),
    .upper_we(upper_we), .upper_d(upper_data),
    .lower_we(lower_we), .lower_d(lower_data),
    .upper_q(upper_q), .lower_q(lower_q)
  );

  iscr_lane_pack #(.ROW_AW(ROW_AW)) u_pack (
    .upper_w(upper_q), .lower_w(lower_q), .big_endian(big_endian),
    .index(cmd_index), .row(img_row), .mask(img_mask), .data(img_data)
  );

  iscr_wr_stage #(.ROW_AW(ROW_AW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_valid), .in_ready(cmd_ready),
    .in_row(img_row), .in_mask(img_mask), .in_data(img_data),
    .out_valid(mem_wvalid), .out_ready(mem_wready),
    .out_row(mem_row), .out_mask(mem_wmask), .out_data(mem_wdata)
  );

  // R3: a stalled slot refuses commands
  a_r3_refuse_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |-> !cmd_ready);
  // R4: accepted row reaches the port
  a_r4_row_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> mem_row == $past(cmd_index[IDX_W-1:4]));
endmodule

// File: tb/iscr_loader_test.sv
module iscr_loader_test;
  localparam int ROW_AW = 3;
  localparam int ROWS   = 1 << ROW_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upper_we = 0, lower_we = 0, big_endian = 0, cmd_valid = 0, mem_wready = 1;
  logic [31:0] upper_data = '0, lower_data = '0;
  logic [ROW_AW+3:0] cmd_index = '0;
  logic cmd_ready, mem_wvalid;
  logic [ROW_AW-1:0] mem_row;
  logic [1:0] mem_wmask;
  logic [127:0] mem_wdata;

  int n_cmp = 0, n_bad = 0;
  logic [127:0] model [ROWS];
  logic [127:0] expect_mem [ROWS];

  always #5 clk = ~clk;

  iscr_loader #(.ROW_AW(ROW_AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .upper_we(upper_we), .upper_data(upper_data),
    .lower_we(lower_we), .lower_data(lower_data),
    .big_endian(big_endian), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_row(mem_row), .mem_wmask(mem_wmask), .mem_wdata(mem_wdata)
  );

  // scratchpad model driven only from the write port
  always @(posedge clk) begin
    if (rst_n && mem_wvalid && mem_wready) begin
      if (mem_wmask[0]) model[mem_row][63:0]   <= mem_wdata[63:0];
      if (mem_wmask[1]) model[mem_row][127:64] <= mem_wdata[127:64];
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] up_val(int r, int h, int be);
    return 32'hA000_0000 | (r << 8) | (h << 4) | be;
  endfunction
  function automatic logic [31:0] lo_val(int r, int h, int be);
    return 32'h5000_0000 | (r << 12) | (h << 4) | be;
  endfunction
  function automatic logic [63:0] half_img(logic [31:0] u, logic [31:0] l, int be);
    return be ? {l, u} : {u, l};
  endfunction
  function automatic logic [127:0] full_img(int h, logic [63:0] v);
    return h ? {v, 64'h0} : {64'h0, v};
  endfunction

  task automatic stage(input logic [31:0] u, input logic [31:0] l);
    @(negedge clk);
    upper_we = 1; lower_we = 1; upper_data = u; lower_data = l;
    @(negedge clk);
    upper_we = 0; lower_we = 0;
  endtask

  // offer a store at a falling edge; returns after the accept edge + 1
  task automatic store(input logic [ROW_AW+3:0] idx, input logic be);
    @(negedge clk);
    big_endian = be; cmd_index = idx; cmd_valid = 1;
    @(posedge clk);
    #1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin model[r] = '0; expect_mem[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(!mem_wvalid, "R1 wvalid low", {127'd0, mem_wvalid}, 0);
    check(cmd_ready, "R1 ready high", {127'd0, cmd_ready}, 1);
    store(7'h08, 1'b1);
    check(mem_wdata == '0 && mem_wmask == 2'b10, "R1 zero staging store",
          mem_wdata, 0);
    @(negedge clk);
    check(!mem_wvalid, "R11 wvalid falls after drain", {127'd0, mem_wvalid}, 0);

    // sweep: both endiannesses, every row, both halves, varied low bits
    for (int be = 0; be < 2; be++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int h = 0; h < 2; h++) begin
          logic [ROW_AW+3:0] idx;
          logic [127:0] exp;
          idx = (ROW_AW+4)'((r << 4) | (h << 3) | ((r + h + be) & 7));
          stage(up_val(r, h, be), lo_val(r, h, be));
          @(negedge clk);
          big_endian = 1'(be); cmd_index = idx; cmd_valid = 1;
          @(posedge clk); #1;
          exp = full_img(h, half_img(up_val(r, h, be), lo_val(r, h, be), be));
          check(mem_wvalid && mem_row == ROW_AW'(r), "R4 row/valid",
                {{(128-ROW_AW){1'b0}}, mem_row}, 128'(r));
          check(mem_wmask == (h ? 2'b10 : 2'b01), "R4 half mask",
                {126'd0, mem_wmask}, h ? 2 : 1);
          check(mem_wdata == exp, "R5 R6 R7 lane order", mem_wdata, exp);
          @(negedge clk); cmd_valid = 0;
          expect_mem[r][h*64 +: 64] = exp[h*64 +: 64];
        end
      end
    end
    // untouched-neighbour pass: only row 0 half 1, little-endian
    stage(32'h1111_2222, 32'h3333_4444);
    store(7'h0C, 1'b0);
    expect_mem[0][127:64] = {32'h1111_2222, 32'h3333_4444};
    repeat (2) @(negedge clk);
    for (int r = 0; r < ROWS; r++)
      check(model[r] == expect_mem[r], "R6 rows keep contents", model[r], expect_mem[r]);

    // R9 repeated store, staging retained
    store(7'h10, 1'b1);
    check(mem_wdata[63:0] == {32'h3333_4444, 32'h1111_2222}, "R9 first repeat",
          mem_wdata, {64'h0, 32'h3333_4444, 32'h1111_2222});
    store(7'h10, 1'b1);
    check(mem_wdata[63:0] == {32'h3333_4444, 32'h1111_2222}, "R9 second repeat",
          mem_wdata, {64'h0, 32'h3333_4444, 32'h1111_2222});

    // R2 independent strobe: only the lower word changes
    @(negedge clk); lower_we = 1; lower_data = 32'hBEEF_0001;
    @(negedge clk); lower_we = 0;
    store(7'h00, 1'b1);
    check(mem_wdata[63:0] == {32'hBEEF_0001, 32'h1111_2222}, "R2 lower only",
          mem_wdata, {64'h0, 32'hBEEF_0001, 32'h1111_2222});

    // R10 staging write at the accept edge is not seen
    @(negedge clk);
    upper_we = 1; upper_data = 32'hDEAD_0002;
    big_endian = 1; cmd_index = 7'h00; cmd_valid = 1;
    @(posedge clk); #1;
    check(mem_wdata[31:0] == 32'h1111_2222, "R10 same-edge staging",
          mem_wdata, {96'h0, 32'h1111_2222});
    @(negedge clk); upper_we = 0; cmd_valid = 0;

    // R8 / R10 / R11 back-pressure
    @(negedge clk);
    mem_wready = 0; cmd_index = 7'h28; big_endian = 0; cmd_valid = 1;
    @(posedge clk); #1;
    // pending: row 2 half 1, little: {upper, lower} = {DEAD_0002, BEEF_0001}
    @(negedge clk);
    upper_we = 1; upper_data = 32'hCAFE_0003; cmd_index = 7'h30;
    @(negedge clk); upper_we = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cmd_ready, "R8 ready low while stalled", {127'd0, cmd_ready}, 0);
      check(mem_wvalid && mem_row == 3'd2 && mem_wmask == 2'b10 &&
            mem_wdata[127:64] == {32'hDEAD_0002, 32'hBEEF_0001},
            "R8 R10 stalled write frozen", mem_wdata,
            {32'hDEAD_0002, 32'hBEEF_0001, 64'h0});
    end
    mem_wready = 1;
    @(posedge clk); #1;
    check(mem_wvalid && mem_row == 3'd3 && mem_wmask == 2'b01 &&
          mem_wdata[63:0] == {32'hCAFE_0003, 32'hBEEF_0001},
          "R3 R11 accepted on drain edge", mem_wdata,
          {64'h0, 32'hCAFE_0003, 32'hBEEF_0001});
    @(negedge clk); cmd_valid = 0;
    repeat (2) @(negedge clk);
    check(model[2][127:64] == {32'hDEAD_0002, 32'hBEEF_0001}, "R8 stalled write landed",
          model[2], {32'hDEAD_0002, 32'hBEEF_0001, 64'h0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule